// File: doc/BRIEF.md
# Saturating Fine-Trim Up/Down Counter

This block holds a fine trim level as an unsigned word that an operator nudges up or down with two push inputs, one to raise and one to lower. The inputs may come from a panel switch or a remote line, so each one passes through a synchronizer and a stability filter before it can act. While exactly one filtered input is held, the block steps the word by one at once and then again at a fixed repeat interval set by an internal period counter. The word is meant to drive an external digital-to-analog converter that sets the trim voltage.

The word never wraps. When it reaches all ones, raise steps are blocked. When it reaches all zeros, lower steps are blocked. Two flags report these limits. If both inputs are held together, the word does not move. Reset sets the word to mid-scale.

Top module: `fine_trim_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `trim_o` equals mid-scale (0x80 for the default 8-bit width), and both `at_max_o` and `at_min_o` are 0.
- R2: A pulse on `raise_i` or `lower_i` that lasts fewer than `DEB_TICKS` clock cycles leaves `trim_o` unchanged.
- R3: Holding `raise_i` alone for longer than the filter time makes `trim_o` rise by one as the first step. No repeat period has to pass first.
- R4: While an input stays held, consecutive steps of `trim_o` are exactly `STEP_PERIOD` clock cycles apart.
- R5: Holding `lower_i` alone makes `trim_o` fall by one per step.
- R6: At 0xFF, `trim_o` holds its value while raise stays held and never wraps to 0x00. `at_max_o` is 1 exactly when `trim_o` is 0xFF.
- R7: At 0x00, `trim_o` holds its value while lower stays held and never wraps to 0xFF. `at_min_o` is 1 exactly when `trim_o` is 0x00.
- R8: While `raise_i` and `lower_i` are both held, `trim_o` does not change.
- R9: Every change of `trim_o` is by exactly one count, up or down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_i | input | 1 | Raise request, active high, asynchronous |
| lower_i | input | 1 | Lower request, active high, asynchronous |
| trim_o | output | WIDTH | Trim word sent to the external converter |
| at_max_o | output | 1 | Set while the trim word is all ones |
| at_min_o | output | 1 | Set while the trim word is all zeros |

## Verification
The assertions assume that reset is held for at least two clock edges, so that the previous-value checks on the trim word start from a defined mid-scale value. They also assume the inputs are free to change at any time, since the synchronizer makes no demand on their timing. The stimulus holds reset for several cycles. It changes the inputs only between clock edges. It releases a held input one cycle after the expected step, so no extra step can start before the filtered release.

// File: rtl/fine_trim_pkg.sv
package fine_trim_pkg;

   typedef enum logic [1:0] {
      ADJ_IDLE = 2'b00,
      ADJ_UP   = 2'b01,
      ADJ_DOWN = 2'b10
   } adj_dir_e;

   function automatic adj_dir_e decode_dir(input logic up_req, input logic dn_req);
      adj_dir_e d;
      unique case ({dn_req, up_req})
         2'b01:   d = ADJ_UP;
         2'b10:   d = ADJ_DOWN;
         default: d = ADJ_IDLE;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/trim_input_filter.sv
module trim_input_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic clean_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("trim_input_filter: SYNC_STAGES must be at least 2");
   end
   if (DEB_TICKS < 1) begin : g_bad_deb
      $error("trim_input_filter: DEB_TICKS must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sampled;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign sampled = sync_q[SYNC_STAGES-1];

   if (DEB_TICKS == 1) begin : g_direct
      logic level_q;
      always_ff @(posedge clk) begin
         if (rst) level_q <= 1'b0;
         else     level_q <= sampled;
      end
      assign clean_o = level_q;
   end else begin : g_counted
      localparam int CW = $clog2(DEB_TICKS);
      localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

      logic          level_q;
      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
         end else if (sampled == level_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            level_q <= sampled;
            run_q   <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
      assign clean_o = level_q;
   end

endmodule

// File: rtl/trim_step_timer.sv
module trim_step_timer
   import fine_trim_pkg::*;
#(
   parameter int STEP_PERIOD = 1000
) (
   input  logic     clk,
   input  logic     rst,
   input  adj_dir_e dir_i,
   input  logic     at_max_i,
   input  logic     at_min_i,
   output logic     step_up_o,
   output logic     step_dn_o
);

   if (STEP_PERIOD < 1) begin : g_bad_period
      $error("trim_step_timer: STEP_PERIOD must be at least 1");
   end

   adj_dir_e prev_q;
   logic     active;
   logic     fire;

   assign active = (dir_i != ADJ_IDLE);

   always_ff @(posedge clk) begin
      if (rst) prev_q <= ADJ_IDLE;
      else     prev_q <= dir_i;
   end

   if (STEP_PERIOD == 1) begin : g_every_cycle
      assign fire = active;
   end else begin : g_divided
      localparam int PW = $clog2(STEP_PERIOD);
      localparam logic [PW-1:0] WRAP = PW'(STEP_PERIOD - 1);

      logic [PW-1:0] gap_q;
      logic          fresh;

      assign fresh = active && (dir_i != prev_q);
      assign fire  = active && (fresh || gap_q == WRAP);

      always_ff @(posedge clk) begin
         if (rst || !active) gap_q <= '0;
         else if (fire)      gap_q <= '0;
         else                gap_q <= gap_q + 1'b1;
      end
   end

   assign step_up_o = fire && (dir_i == ADJ_UP)   && !at_max_i;
   assign step_dn_o = fire && (dir_i == ADJ_DOWN) && !at_min_i;

endmodule

// File: rtl/trim_sat_counter.sv
module trim_sat_counter #(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] RESET_LEVEL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [WIDTH-1:0] level_o,
   output logic             at_max_o,
   output logic             at_min_o
);

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic [WIDTH-1:0] level_q;

   always_ff @(posedge clk) begin
      if (rst)                   level_q <= RESET_LEVEL;
      else if (inc_i && !dec_i)  level_q <= level_q + 1'b1;
      else if (dec_i && !inc_i)  level_q <= level_q - 1'b1;
   end

   assign level_o  = level_q;
   assign at_max_o = (level_q == TOP);
   assign at_min_o = (level_q == '0);

endmodule

// File: rtl/fine_trim_ctrl.sv
module fine_trim_ctrl
   import fine_trim_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               DEB_TICKS   = 16,
   parameter int               STEP_PERIOD = 100000,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_LEVEL = WIDTH'(1) << (WIDTH - 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             raise_i,
   input  logic             lower_i,
   output logic [WIDTH-1:0] trim_o,
   output logic             at_max_o,
   output logic             at_min_o
);

   localparam int NCH = 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("fine_trim_ctrl: WIDTH must be at least 2");
   end

   logic [NCH-1:0] raw_req;
   logic [NCH-1:0] clean_req;
   adj_dir_e       dir;
   logic           step_up;
   logic           step_dn;
   logic           lim_hi;
   logic           lim_lo;

   assign raw_req = {lower_i, raise_i};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      trim_input_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .DEB_TICKS  (DEB_TICKS)
      ) u_filter (
         .clk    (clk),
         .rst    (rst),
         .raw_i  (raw_req[ch]),
         .clean_o(clean_req[ch])
      );
   end

   assign dir = decode_dir(clean_req[0], clean_req[1]);

   trim_step_timer #(
      .STEP_PERIOD(STEP_PERIOD)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .dir_i    (dir),
      .at_max_i (lim_hi),
      .at_min_i (lim_lo),
      .step_up_o(step_up),
      .step_dn_o(step_dn)
   );

   trim_sat_counter #(
      .WIDTH      (WIDTH),
      .RESET_LEVEL(RESET_LEVEL)
   ) u_count (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (step_up),
      .dec_i   (step_dn),
      .level_o (trim_o),
      .at_max_o(lim_hi),
      .at_min_o(lim_lo)
   );

   assign at_max_o = lim_hi;
   assign at_min_o = lim_lo;

endmodule

// File: rtl/fine_trim_ctrl_chk.sv
module fine_trim_ctrl_chk #(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] RESET_LEVEL = '0
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] trim_o,
   input logic             at_max_o,
   input logic             at_min_o
);

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   assert_reset_level_R1: assert property (@(posedge clk)
      rst |=> (trim_o == RESET_LEVEL));

   assert_unit_step_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(trim_o) |-> ((trim_o - $past(trim_o)) == ONE ||
                            ($past(trim_o) - trim_o) == ONE));

   assert_no_wrap_high_R6: assert property (@(posedge clk) disable iff (rst)
      (trim_o == TOP) |=> (trim_o != '0));

   assert_no_wrap_low_R7: assert property (@(posedge clk) disable iff (rst)
      (trim_o == '0) |=> (trim_o != TOP));

   assert_max_flag_sticks_R6: assert property (@(posedge clk) disable iff (rst)
      (at_max_o && !at_min_o) |=> (at_max_o || (trim_o == TOP - ONE)));

endmodule

bind fine_trim_ctrl fine_trim_ctrl_chk #(
   .WIDTH      (WIDTH),
   .RESET_LEVEL(RESET_LEVEL)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .trim_o  (trim_o),
   .at_max_o(at_max_o),
   .at_min_o(at_min_o)
);

// File: tb/fine_trim_ctrl_bench.sv
module fine_trim_ctrl_bench;

   localparam int W      = 8;
   localparam int DEB    = 4;
   localparam int PERIOD = 12;

   typedef struct {
      logic [W-1:0] value;
      bit           gap_chk;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         raise_i = 1'b0;
   logic         lower_i = 1'b0;
   logic [W-1:0] trim_o;
   logic         at_max_o;
   logic         at_min_o;

   int   n_checks = 0;
   int   n_fail   = 0;
   int   cyc      = 0;
   exp_t q[$];
   logic [W-1:0] model = 8'h80;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fine_trim_ctrl #(
      .WIDTH(W), .DEB_TICKS(DEB), .STEP_PERIOD(PERIOD), .SYNC_STAGES(2)
   ) u_fine_trim_ctrl (
      .clk(clk), .rst(rst), .raise_i(raise_i), .lower_i(lower_i),
      .trim_o(trim_o), .at_max_o(at_max_o), .at_min_o(at_min_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: every change of trim_o is compared with the next expected item.
   logic [W-1:0] last_trim;
   int           last_cyc = 0;
   bit           mon_on = 1'b0;
   always @(negedge clk) begin
      if (mon_on && trim_o !== last_trim) begin
         if (q.size() == 0) begin
            check(1'b0, "R2/R8 unexpected step", int'(trim_o), int'(last_trim));
         end else begin
            exp_t e;
            e = q.pop_front();
            check(trim_o === e.value, e.req, int'(trim_o), int'(e.value));
            if (e.gap_chk)
               check((cyc - last_cyc) == PERIOD, "R4 step spacing", cyc - last_cyc, PERIOD);
         end
         last_cyc = cyc;
      end
      last_trim = trim_o;
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Driver: hold one input for n steps, optionally keep holding at a limit.
   task automatic hold(input bit up, input int n, input int extra, input string req);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         model  = up ? model + 8'd1 : model - 8'd1;
         e.value = model;
         e.gap_chk = (i > 0);
         e.req = req;
         q.push_back(e);
      end
      if (up) raise_i = 1'b1; else lower_i = 1'b1;
      while (q.size() != 0) @(posedge clk);
      #1;
      if (extra > 0) begin
         idle(extra);
         @(negedge clk);
         check(trim_o === model, up ? "R6 held at max" : "R7 held at min",
               int'(trim_o), int'(model));
         #1;
      end
      raise_i = 1'b0;
      lower_i = 1'b0;
      idle(3 * PERIOD);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      idle(4);
      @(negedge clk);
      check(trim_o === 8'h80, "R1 reset level", int'(trim_o), 8'h80);
      check(at_max_o === 1'b0 && at_min_o === 1'b0, "R1 flags in reset",
            int'({at_max_o, at_min_o}), 0);
      #1 rst = 1'b0;
      @(negedge clk);
      check(trim_o === 8'h80, "R1 after reset release", int'(trim_o), 8'h80);
      last_trim = trim_o;
      mon_on = 1'b1;
      #1;

      // R2: short glitches on each input are filtered
      raise_i = 1'b1; idle(DEB - 2); raise_i = 1'b0;
      idle(40);
      lower_i = 1'b1; idle(DEB - 2); lower_i = 1'b0;
      idle(40);
      @(negedge clk);
      check(trim_o === 8'h80, "R2 glitch ignored", int'(trim_o), 8'h80);
      #1;

      // R3, R4: raise steps
      hold(1'b1, 3, 0, "R3 raise step");
      // R5: lower steps
      hold(1'b0, 5, 0, "R5 lower step");

      // R8: both held together
      raise_i = 1'b1; lower_i = 1'b1;
      idle(8 * PERIOD);
      @(negedge clk);
      check(trim_o === model, "R8 both held", int'(trim_o), int'(model));
      #1;
      raise_i = 1'b0; lower_i = 1'b0;
      idle(3 * PERIOD);

      // R6: run to the top and keep pushing
      hold(1'b1, 255 - int'(model), 6 * PERIOD, "R6 raise to max");
      @(negedge clk);
      check(at_max_o === 1'b1 && at_min_o === 1'b0, "R6 max flag",
            int'({at_max_o, at_min_o}), 2);
      #1;

      // R7: run to the bottom and keep pushing
      hold(1'b0, int'(model), 6 * PERIOD, "R7 lower to min");
      @(negedge clk);
      check(at_min_o === 1'b1 && at_max_o === 1'b0, "R7 min flag",
            int'({at_max_o, at_min_o}), 1);
      #1;

      // R3: recover from the bottom
      hold(1'b1, 2, 0, "R3 raise from min");
      @(negedge clk);
      check(at_min_o === 1'b0 && trim_o === 8'h02, "R9 left min by unit steps",
            int'(trim_o), 2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule